// File: doc/BRIEF.md
# Host Data Window with Read Prefetch Queue

This block lets a host processor move 16-bit words into and out of a coprocessor's memory spaces through a single data port. The host programs an address register and a configuration register, then writes words to the data port (each one is forwarded to the selected memory region) or reads words from it. Reads are served from a 16-entry queue that a prefetch engine fills from the selected region. The engine runs for one word, for a short burst, for a full queue, or continuously until cancelled.

The host side uses a request/acknowledge handshake. The host holds `hst_req` until it sees a one-cycle `hst_ack`, which comes with the read data. The memory side is a request port: `mem_req` is held until the memory returns a one-cycle `mem_ack`, which comes with the read data. An interrupt line pulses for one cycle when a transfer starts, when a data-port write completes, and when a data-port read leaves words in the queue.

Top module: `host_data_window`

## Requirements
- R1: `hst_sel` picks the target register: 0 is the data port, 1 the address register, 2 the configuration register and 3 the status word. After reset the address and the configuration read 0, the status reads 0x0100, `irq` is low and no memory request is made.
- R2: Configuration bits 3:2 set the transfer length. Code 0 fetches 1 word, code 1 fetches 8 words and code 2 fetches 16 words. Fetching then stops, and data-port reads return the words in address order.
- R3: Length code 3 is continuous. The first fill stops when the queue holds 16 words, each later data read is followed by a one-word refill, and the transfer never ends by itself. The queue never takes a word while it is full.
- R4: A configuration write with bit 4 set starts a transfer. A configuration write with bit 4 clear cancels it: the remaining count is cleared, the queue is flushed and fetching stops. A data read with an empty queue and nothing remaining returns 0.
- R5: Configuration bits 14:12 pick the region: 0 data memory, 1 register space, 5 program memory, 7 external bus. For the register space only the low 11 address bits are driven and the upper bits are 0. With any other code a data write makes no memory request, no address step and no interrupt, and a fetch pushes 0 into the queue without any memory request or address step.
- R6: With configuration bit 1 set, the address register steps by 1 after each memory access and wraps from 0xFFFF to 0x0000. With bit 1 clear it stays unchanged.
- R7: In the status word, bits 0 and 6 are set when the queue is not empty, bit 5 is set when it is full, bit 8 is always 1, and every other bit is 0. Writes to the status select are ignored.
- R8: `irq` pulses for a single cycle on a transfer start, on completion of a data write to a valid region, and on a data read that leaves the queue non-empty.
- R9: A data read that finds the queue empty while words remain is not acknowledged until the fetched word has arrived, and it then returns that word.
- R10: `mem_req` stays high, with address, region, direction and write data stable, until `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hst_req | input | 1 | Host access request, held until `hst_ack` |
| hst_we | input | 1 | 1 = write, 0 = read |
| hst_sel | input | 2 | Register select (0 data, 1 address, 2 config, 3 status) |
| hst_wdata | input | 16 | Host write data |
| hst_ack | output | 1 | One-cycle access acknowledge |
| hst_rdata | output | 16 | Read data, valid with `hst_ack` |
| irq | output | 1 | One-cycle interrupt pulse |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory access direction, 1 = write |
| mem_region | output | 3 | Target region code |
| mem_addr | output | 16 | Target word address |
| mem_wdata | output | 16 | Memory write data |
| mem_ack | input | 1 | Memory acknowledge, one cycle |
| mem_rdata | input | 16 | Memory read data, valid with `mem_ack` |

## Verification
The prefetch path is driven with each of the four length codes. The word counts seen on the memory port separate 1, 8, 16 and continuous transfers, and the returned values, which depend on the address, show that the order and the address steps are correct. The continuous run is read once and then cancelled, which shows the single-word refill and that the flush really stops traffic. The write path is tried in a valid region, in the register space with an address above 11 bits, and in an unused region code, which separates masking from suppression. A read issued right after a start, with the queue still empty, shows the stall.

// File: rtl/hdw_pkg.sv
// Package: shared encodings for the host data window.
// Assumes a 16-bit configuration word whose field positions are fixed.
package hdw_pkg;

    typedef enum logic [1:0] {
        SEL_DATA = 2'd0,
        SEL_ADDR = 2'd1,
        SEL_CFG  = 2'd2,
        SEL_STAT = 2'd3
    } hdw_sel_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_WRITE = 2'd2
    } hdw_state_e;

    localparam logic [2:0] RGN_DATA = 3'd0;
    localparam logic [2:0] RGN_REGS = 3'd1;
    localparam logic [2:0] RGN_PROG = 3'd5;
    localparam logic [2:0] RGN_EXT  = 3'd7;

    localparam int CFG_STEP_BIT = 1;
    localparam int CFG_LEN_LO   = 2;
    localparam int CFG_RUN_BIT  = 4;
    localparam int CFG_RGN_LO   = 12;

    // Only four region codes lead to a real memory access.
    function automatic logic region_ok(input logic [2:0] r);
        return (r == RGN_DATA) || (r == RGN_REGS) || (r == RGN_PROG) || (r == RGN_EXT);
    endfunction

endpackage

// File: rtl/hdw_fifo.sv
// Module: hdw_fifo
// Synchronous queue of DEPTH words with a flush input. A flush wins over a
// push in the same cycle. The caller never pushes when full and never pops
// when empty.
module hdw_fifo #(
    parameter int DW    = 16,
    parameter int DEPTH = 16,
    localparam int PW   = $clog2(DEPTH),
    localparam int CW   = PW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] din,
    input  logic          pop,
    input  logic          flush,
    output logic [DW-1:0] head,
    output logic          empty,
    output logic          full,
    output logic [CW-1:0] count
);
    logic [DW-1:0] store [DEPTH];
    logic [PW-1:0] wp_q, rp_q;
    logic [CW-1:0] cnt_q;

    // Pointer and occupancy update.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (push) wp_q <= wp_q + 1'b1;
            if (pop)  rp_q <= rp_q + 1'b1;
            cnt_q <= cnt_q + CW'(push) - CW'(pop);
        end
    end

    // Word storage.
    always_ff @(posedge clk) begin
        if (push && !flush) store[wp_q] <= din;
    end

    assign head  = store[rp_q];
    assign empty = (cnt_q == '0);
    assign full  = (cnt_q == CW'(DEPTH));
    assign count = cnt_q;
endmodule

// File: rtl/hdw_prefetch_ctl.sv
// Module: hdw_prefetch_ctl
// Keeps the remaining word count of a read transfer. A start loads it from
// the length code, a cancel clears it, and each fetched word lowers it by one.
// Continuous mode keeps a flag and never counts down.
module hdw_prefetch_ctl #(
    parameter int DEPTH     = 16,
    parameter int SHORT_LEN = 8,
    localparam int CW       = $clog2(DEPTH) + 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       cancel,
    input  logic [1:0] len_code,
    input  logic       word_done,
    output logic       pending
);
    logic [CW-1:0] rem_q;
    logic          cont_q;

    // Remaining count and continuous flag.
    always_ff @(posedge clk) begin
        if (!rst_n || cancel) begin
            rem_q  <= '0;
            cont_q <= 1'b0;
        end else if (start) begin
            cont_q <= (len_code == 2'd3);
            unique case (len_code)
                2'd0:    rem_q <= CW'(1);
                2'd1:    rem_q <= CW'(SHORT_LEN);
                2'd2:    rem_q <= CW'(DEPTH);
                default: rem_q <= '0;
            endcase
        end else if (word_done && !cont_q && rem_q != '0) begin
            rem_q <= rem_q - 1'b1;
        end
    end

    assign pending = cont_q || (rem_q != '0);
endmodule

// File: rtl/host_data_window.sv
// Module: host_data_window
// Host-side window into the coprocessor memories: address and configuration
// registers, a data port that forwards writes, and read prefetch into a
// queue. Assumes the host holds hst_req until hst_ack and the memory holds
// mem_ack for one cycle only. DW must be at least 16 (configuration layout).
module host_data_window #(
    parameter int DW       = 16,
    parameter int AW       = 16,
    parameter int DEPTH    = 16,
    parameter int REGSP_AW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hst_req,
    input  logic          hst_we,
    input  logic [1:0]    hst_sel,
    input  logic [DW-1:0] hst_wdata,
    output logic          hst_ack,
    output logic [DW-1:0] hst_rdata,
    output logic          irq,
    output logic          mem_req,
    output logic          mem_we,
    output logic [2:0]    mem_region,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic          mem_ack,
    input  logic [DW-1:0] mem_rdata
);
    import hdw_pkg::*;

    localparam int CW = $clog2(DEPTH) + 1;

    hdw_state_e    st_q;
    logic [AW-1:0] addr_q, tgt_addr, maddr_q;
    logic [DW-1:0] cfg_q, rdata_q, wdata_q, status, fifo_din, fifo_head;
    logic [2:0]    rgn, mrgn_q;
    logic          rgn_ok, ack_q, irq_q;
    logic          fifo_push, fifo_pop, fifo_flush, fifo_empty, fifo_full;
    logic [CW-1:0] fifo_cnt;
    logic          pf_start, pf_cancel, pf_pending;
    logic          data_rd, rd_wait, accept, launch, cfg_wr, data_wr_go;
    logic          fetch_ack, write_ack, step;
    hdw_sel_e      sel;

    assign sel      = hdw_sel_e'(hst_sel);
    assign rgn      = cfg_q[CFG_RGN_LO +: 3];
    assign rgn_ok   = region_ok(rgn);
    assign tgt_addr = (rgn == RGN_REGS) ? AW'(addr_q[REGSP_AW-1:0]) : addr_q;

    // Host arbitration: a data read waits while the queue is empty and words remain.
    assign data_rd    = hst_req && !hst_we && (sel == SEL_DATA);
    assign rd_wait    = data_rd && fifo_empty && pf_pending;
    assign accept     = hst_req && (st_q == ST_IDLE) && !ack_q && !rd_wait;
    assign launch     = (st_q == ST_IDLE) && !accept && pf_pending && !fifo_full;
    assign cfg_wr     = accept && hst_we && (sel == SEL_CFG);
    assign data_wr_go = accept && hst_we && (sel == SEL_DATA) && rgn_ok;
    assign pf_start   = cfg_wr && hst_wdata[CFG_RUN_BIT];
    assign pf_cancel  = cfg_wr && !hst_wdata[CFG_RUN_BIT];
    assign fetch_ack  = (st_q == ST_FETCH) && mem_ack;
    assign write_ack  = (st_q == ST_WRITE) && mem_ack;
    assign step       = (fetch_ack || write_ack) && cfg_q[CFG_STEP_BIT];

    // Queue feed: fetched words, or zero for a fetch from an unused region.
    assign fifo_push  = fetch_ack || (launch && !rgn_ok);
    assign fifo_din   = fetch_ack ? mem_rdata : '0;
    assign fifo_pop   = accept && data_rd && !fifo_empty;
    assign fifo_flush = pf_cancel;

    // Status word assembly.
    always_comb begin
        status    = '0;
        status[8] = 1'b1;
        status[6] = !fifo_empty;
        status[5] = fifo_full;
        status[0] = !fifo_empty;
    end

    hdw_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(fifo_push), .din(fifo_din),
        .pop(fifo_pop), .flush(fifo_flush), .head(fifo_head),
        .empty(fifo_empty), .full(fifo_full), .count(fifo_cnt)
    );

    hdw_prefetch_ctl #(.DEPTH(DEPTH), .SHORT_LEN(DEPTH / 2)) u_pf (
        .clk(clk), .rst_n(rst_n), .start(pf_start), .cancel(pf_cancel),
        .len_code(hst_wdata[CFG_LEN_LO +: 2]), .word_done(fifo_push),
        .pending(pf_pending)
    );

    // Memory access sequencer and latched request fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= ST_IDLE;
            maddr_q <= '0;
            mrgn_q  <= '0;
            wdata_q <= '0;
        end else begin
            unique case (st_q)
                ST_IDLE: begin
                    if (data_wr_go) begin
                        st_q    <= ST_WRITE;
                        maddr_q <= tgt_addr;
                        mrgn_q  <= rgn;
                        wdata_q <= hst_wdata;
                    end else if (launch && rgn_ok) begin
                        st_q    <= ST_FETCH;
                        maddr_q <= tgt_addr;
                        mrgn_q  <= rgn;
                    end
                end
                default: if (mem_ack) st_q <= ST_IDLE;
            endcase
        end
    end

    // Address and configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            cfg_q  <= '0;
        end else begin
            if (accept && hst_we && sel == SEL_ADDR) addr_q <= AW'(hst_wdata);
            else if (step)                           addr_q <= addr_q + 1'b1;
            if (cfg_wr) cfg_q <= hst_wdata;
        end
    end

    // Host response and interrupt pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_q   <= 1'b0;
            rdata_q <= '0;
            irq_q   <= 1'b0;
        end else begin
            ack_q <= (accept && !data_wr_go) || write_ack;
            irq_q <= pf_start || write_ack || (fifo_pop && fifo_cnt > CW'(1));
            if (accept && !hst_we) begin
                unique case (sel)
                    SEL_DATA: rdata_q <= fifo_empty ? '0 : fifo_head;
                    SEL_ADDR: rdata_q <= DW'(addr_q);
                    SEL_CFG:  rdata_q <= cfg_q;
                    default:  rdata_q <= status;
                endcase
            end
        end
    end

    assign hst_ack    = ack_q;
    assign hst_rdata  = rdata_q;
    assign irq        = irq_q;
    assign mem_req    = (st_q != ST_IDLE);
    assign mem_we     = (st_q == ST_WRITE);
    assign mem_region = mrgn_q;
    assign mem_addr   = maddr_q;
    assign mem_wdata  = wdata_q;
endmodule

// File: rtl/hdw_checker.sv
// Module: hdw_checker
// Property checks for host_data_window, attached with bind below.
// Assumes it sees the top's ports and its internal queue and cancel signals.
module hdw_checker #(
    parameter int DW       = 16,
    parameter int AW       = 16,
    parameter int REGSP_AW = 11
) (
    input logic          clk,
    input logic          rst_n,
    input logic          mem_req,
    input logic          mem_we,
    input logic          mem_ack,
    input logic [2:0]    mem_region,
    input logic [AW-1:0] mem_addr,
    input logic [DW-1:0] mem_wdata,
    input logic          hst_ack,
    input logic          irq,
    input logic          fifo_full,
    input logic          fifo_push,
    input logic          fifo_empty,
    input logic          pf_cancel
);
    AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we)
            && $stable(mem_region) && $stable(mem_wdata)); // R10

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_full |-> !fifo_push); // R3

    AST_CANCEL_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        pf_cancel |=> fifo_empty); // R4

    AST_REGION_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_region == 3'd0 || mem_region == 3'd1
                     || mem_region == 3'd5 || mem_region == 3'd7)); // R5

    AST_REGSP_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_region == 3'd1 |-> mem_addr[AW-1:REGSP_AW] == '0); // R5

    AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq); // R8

    AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        hst_ack |=> !hst_ack); // R9
endmodule

bind host_data_window hdw_checker #(.DW(DW), .AW(AW), .REGSP_AW(REGSP_AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_we(mem_we),
    .mem_ack(mem_ack), .mem_region(mem_region), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .hst_ack(hst_ack), .irq(irq),
    .fifo_full(fifo_full), .fifo_push(fifo_push), .fifo_empty(fifo_empty),
    .pf_cancel(pf_cancel)
);

// File: tb/host_data_window_bench.sv
// Directed bench for host_data_window: one task per scenario.
module host_data_window_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hst_req = 1'b0, hst_we = 1'b0;
    logic [1:0]  hst_sel = 2'd0;
    logic [15:0] hst_wdata = 16'h0;
    logic        hst_ack, irq, mem_req, mem_we;
    logic [15:0] hst_rdata, mem_addr, mem_wdata;
    logic [2:0]  mem_region;
    logic        mem_ack = 1'b0;
    logic [15:0] mem_rdata;

    int checks = 0, failures = 0;
    int rd_cnt = 0, wr_cnt = 0, irq_cnt = 0;
    logic [15:0] last_wa = 16'h0, last_wd = 16'h0;
    logic [2:0]  last_wr = 3'd0;
    logic [1:0]  lat = 2'd0;
    bit          timed_out = 1'b0;

    always #10 clk = ~clk;

    host_data_window u_host_data_window (
        .clk(clk), .rst_n(rst_n), .hst_req(hst_req), .hst_we(hst_we),
        .hst_sel(hst_sel), .hst_wdata(hst_wdata), .hst_ack(hst_ack),
        .hst_rdata(hst_rdata), .irq(irq), .mem_req(mem_req), .mem_we(mem_we),
        .mem_region(mem_region), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    function automatic logic [15:0] mdata(input logic [2:0] r, input logic [15:0] a);
        return {r, a[12:0]} ^ 16'h1357;
    endfunction

    assign mem_rdata = mdata(mem_region, mem_addr);

    // Memory model: acknowledge after a short latency, and log accesses.
    always @(posedge clk) begin
        if (!rst_n || !mem_req || mem_ack) begin
            lat <= 2'd0;
            mem_ack <= 1'b0;
        end else if (lat == 2'd2) mem_ack <= 1'b1;
        else lat <= lat + 2'd1;
        if (mem_req && mem_ack) begin
            if (mem_we) begin
                wr_cnt  <= wr_cnt + 1;
                last_wa <= mem_addr;
                last_wd <= mem_wdata;
                last_wr <= mem_region;
            end else rd_cnt <= rd_cnt + 1;
        end
        if (rst_n && irq) irq_cnt <= irq_cnt + 1;
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic xfer(input logic we, input logic [1:0] sel, input logic [15:0] wd,
                        output logic [15:0] rd);
        @(negedge clk);
        hst_req = 1'b1; hst_we = we; hst_sel = sel; hst_wdata = wd;
        do @(negedge clk); while (!hst_ack && !timed_out);
        rd = hst_rdata;
        hst_req = 1'b0;
    endtask

    task automatic wr(input logic [1:0] sel, input logic [15:0] wd);
        logic [15:0] d;
        xfer(1'b1, sel, wd, d);
    endtask

    task automatic rd_expect(input logic [1:0] sel, input logic [15:0] exp, input string req);
        logic [15:0] d;
        xfer(1'b0, sel, 16'h0, d);
        chk(req, d, exp);
    endtask

    task automatic t_reset;
        chk("R1 mem_req", mem_req, 0);
        chk("R1 irq", irq, 0);
        rd_expect(2'd1, 16'h0000, "R1 addr");
        rd_expect(2'd2, 16'h0000, "R1 cfg");
        rd_expect(2'd3, 16'h0100, "R1/R7 status");
    endtask

    task automatic t_single;
        int r0 = rd_cnt, i0 = irq_cnt;
        wr(2'd1, 16'h0100);
        wr(2'd2, 16'h0012);          // data region, step, code 0, run
        idle(40);
        chk("R2 single count", rd_cnt - r0, 1);
        chk("R8 start irq", irq_cnt - i0, 1);
        rd_expect(2'd3, 16'h0141, "R7 not empty");
        rd_expect(2'd0, mdata(3'd0, 16'h0100), "R2 single data");
        idle(3);
        chk("R8 no irq when drained", irq_cnt - i0, 1);
        rd_expect(2'd3, 16'h0100, "R7 empty");
        rd_expect(2'd0, 16'h0000, "R4 empty read");
        rd_expect(2'd1, 16'h0101, "R6 step");
    endtask

    task automatic t_burst8;
        int r0 = rd_cnt;
        wr(2'd1, 16'h0200);
        wr(2'd2, 16'h5016);          // program region, step, code 1, run
        idle(80);
        chk("R2 burst8 count", rd_cnt - r0, 8);
        for (int i = 0; i < 8; i++)
            rd_expect(2'd0, mdata(3'd5, 16'h0200 + 16'(i)), "R2 burst8 data");
        rd_expect(2'd3, 16'h0100, "R2 burst8 drained");
        rd_expect(2'd1, 16'h0208, "R6 burst8 addr");
    endtask

    task automatic t_burst16;
        int r0 = rd_cnt;
        wr(2'd1, 16'hFFF8);
        wr(2'd2, 16'h101A);          // register space, step, code 2, run
        idle(150);
        chk("R2 burst16 count", rd_cnt - r0, 16);
        rd_expect(2'd3, 16'h0161, "R7 full");
        for (int i = 0; i < 16; i++) begin
            logic [15:0] a = 16'hFFF8 + 16'(i);
            rd_expect(2'd0, mdata(3'd1, a & 16'h07FF), "R5 regspace data");
        end
        rd_expect(2'd1, 16'h0008, "R6 wrap");
    endtask

    task automatic t_cont;
        int r0 = rd_cnt, i0;
        wr(2'd1, 16'h0400);
        wr(2'd2, 16'h701E);          // external region, step, code 3, run
        idle(150);
        chk("R3 first fill capped", rd_cnt - r0, 16);
        rd_expect(2'd3, 16'h0161, "R3 full");
        i0 = irq_cnt;
        rd_expect(2'd0, mdata(3'd7, 16'h0400), "R3 cont data");
        idle(20);
        chk("R8 read irq", irq_cnt - i0, 1);
        chk("R3 refill one", rd_cnt - r0, 17);
        rd_expect(2'd3, 16'h0161, "R3 full again");
        wr(2'd2, 16'h7002);          // cancel
        rd_expect(2'd3, 16'h0100, "R4 flushed");
        idle(30);
        chk("R4 no more fetches", rd_cnt - r0, 17);
        rd_expect(2'd0, 16'h0000, "R4 read after cancel");
    endtask

    task automatic t_stall;
        wr(2'd1, 16'h0030);
        wr(2'd2, 16'h0010);          // data region, no step, code 0, run
        rd_expect(2'd0, mdata(3'd0, 16'h0030), "R9 stalled read");
        rd_expect(2'd1, 16'h0030, "R6 no step");
    endtask

    task automatic t_write;
        int w0 = wr_cnt, i0;
        wr(2'd2, 16'h0002);
        wr(2'd1, 16'h0050);
        i0 = irq_cnt;
        wr(2'd0, 16'hBEEF);
        idle(3);
        chk("R8 write irq", irq_cnt - i0, 1);
        chk("R5 write count", wr_cnt - w0, 1);
        chk("R5 write addr", last_wa, 16'h0050);
        chk("R5 write data", last_wd, 16'hBEEF);
        chk("R5 write region", last_wr, 0);
        rd_expect(2'd1, 16'h0051, "R6 write step");
        wr(2'd2, 16'h1002);
        wr(2'd1, 16'h0ABC);
        wr(2'd0, 16'h1234);
        idle(3);
        chk("R5 regspace mask", last_wa, 16'h02BC);
        chk("R5 regspace region", last_wr, 1);
    endtask

    task automatic t_badregion;
        int w0 = wr_cnt, r0 = rd_cnt, i0;
        wr(2'd2, 16'h3002);
        wr(2'd1, 16'h0077);
        i0 = irq_cnt;
        wr(2'd0, 16'hAAAA);
        idle(5);
        chk("R5 bad write no access", wr_cnt - w0, 0);
        chk("R5 bad write no irq", irq_cnt - i0, 0);
        rd_expect(2'd1, 16'h0077, "R5 bad write no step");
        wr(2'd2, 16'h3012);
        idle(20);
        chk("R5 bad fetch no access", rd_cnt - r0, 0);
        rd_expect(2'd3, 16'h0141, "R5 bad fetch queued");
        rd_expect(2'd0, 16'h0000, "R5 bad fetch zero");
        rd_expect(2'd1, 16'h0077, "R5 bad fetch no step");
    endtask

    task automatic t_nostep_status;
        int w0 = wr_cnt;
        wr(2'd2, 16'h0000);
        wr(2'd1, 16'h0090);
        wr(2'd0, 16'h1111);
        wr(2'd0, 16'h2222);
        idle(3);
        chk("R6 two writes", wr_cnt - w0, 2);
        chk("R6 same addr", last_wa, 16'h0090);
        rd_expect(2'd1, 16'h0090, "R6 held addr");
        wr(2'd3, 16'hFFFF);
        rd_expect(2'd3, 16'h0100, "R7 status write ignored");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        timed_out = 1'b1;
        failures++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        idle(2);
        t_reset;
        t_single;
        t_burst8;
        t_burst16;
        t_cont;
        t_stall;
        t_write;
        t_badregion;
        t_nostep_status;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule